// File: doc/BRIEF.md
# AXI Data Beat Tally

This block sits beside a 128-bit AXI master port and only observes it. It counts the completed data transfers on the read-data channel and on the write-data channel while a measurement window is open. Each direction has its own running counter. A transfer counts when the channel's valid and ready are both high on a rising clock edge.

A separate window generator decides when a window starts and ends. It sends a single-cycle capture pulse. On that pulse, each running count moves into a result register and the running counter starts again from zero. The result registers keep their value until the next capture. Each result also appears as a byte total. Every beat carries 16 bytes, so the byte total is the beat count multiplied by 16, formed with a left shift into a wider word.

The monitored channels keep their own valid/ready rules and are not touched. The block drives no ready and cannot stall or back-pressure the traffic. It samples the handshake only. The window and capture pins are plain level and pulse controls.

Top module: `axi_beat_counter`

## Requirements
- R1: While `rst_n` is low, both beat results and both byte results read zero, and both running counters are cleared.
- R2: A read beat counts only in a cycle where `rd_valid`, `rd_ready` and `win_active` are all high. Valid alone or ready alone adds nothing.
- R3: A write beat counts only in a cycle where `wr_valid`, `wr_ready` and `win_active` are all high. Valid alone or ready alone adds nothing.
- R4: While `win_active` is low, handshakes on either channel leave the running counts unchanged. This includes a cycle that also carries a capture.
- R5: On a cycle with `capture` high, each result register takes the running count plus that cycle's qualified beat, and the running counter is zero after that edge. A beat in the capture cycle therefore belongs to the closing window only.
- R6: The result registers change only on a capture cycle.
- R7: A running counter that reaches all-ones (2^CNT_W-1) holds there and does not wrap. The captured result is then all-ones.
- R8: `rd_bytes` and `wr_bytes` equal the matching beat result times 16. They are CNT_W+4 bits wide (36 by default), so they never overflow.
- R9: The read and write tallies are independent. Traffic on one channel never changes the other channel's counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the monitored port |
| rst_n | input | 1 | Active-low synchronous reset |
| win_active | input | 1 | High while the measurement window is open |
| capture | input | 1 | Single-cycle pulse that closes a window |
| rd_valid | input | 1 | Read-data valid of the monitored port |
| rd_ready | input | 1 | Read-data ready of the monitored port |
| wr_valid | input | 1 | Write-data valid of the monitored port |
| wr_ready | input | 1 | Write-data ready of the monitored port |
| rd_beats | output | 32 | Read beats captured in the last window |
| wr_beats | output | 32 | Write beats captured in the last window |
| rd_bytes | output | 36 | Read bytes of the last window (beats × 16) |
| wr_bytes | output | 36 | Write bytes of the last window (beats × 16) |

## Verification
The stimulus covers every valid/ready pairing on each channel, with the window open and with it closed. This shows that a count needs the full handshake inside the window, and that idle or stalled cycles add nothing. Some capture pulses land on a beat, some land on idle cycles, and one lands back to back with another. These show that a beat on a capture cycle closes the old window and does not carry into the new one. Long runs of beats check the byte scaling. A narrow instance fed 20 beats checks that the counter stops at all-ones and does not wrap.

// File: rtl/axi_beat_pkg.sv
package axi_beat_pkg;
  // index of each monitored data channel
  localparam int unsigned CH_RD = 0;
  localparam int unsigned CH_WR = 1;
  localparam int unsigned NUM_CH = 2;

  // bytes carried by one beat of a 128-bit data bus
  localparam int unsigned BUS_BITS = 128;
  localparam int unsigned BEAT_BYTES = BUS_BITS / 8;
endpackage

// File: rtl/beat_detect.sv
module beat_detect (
  input  logic vld,
  input  logic rdy,
  input  logic win,
  output logic beat
);
  // a beat is one completed handshake inside an open window
  always_comb begin
    beat = vld & rdy & win;
  end
endmodule

// File: rtl/beat_tally.sv
module beat_tally #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             capture,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_next;

  // saturating increment
  always_comb begin
    run_next = run_q;
    if (beat && (run_q != ALL_ONES)) run_next = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      result <= '0;
    end else if (capture) begin
      result <= run_next;
      run_q  <= '0;
    end else begin
      run_q  <= run_next;
    end
  end

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (run_q == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_q == ALL_ONES) && !capture) |=> (run_q == ALL_ONES));

  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !capture) |=> $stable(run_q));
endmodule

// File: rtl/byte_scale.sv
module byte_scale #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned SHIFT = 4
) (
  input  logic [IN_W-1:0]       beats,
  output logic [IN_W+SHIFT-1:0] bytes
);
  always_comb begin
    bytes = {beats, {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/axi_beat_counter.sv
module axi_beat_counter
  import axi_beat_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned SHIFT = $clog2(BEAT_BYTES),
  localparam int unsigned BYTE_W = CNT_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_active,
  input  logic              capture,
  input  logic              rd_valid,
  input  logic              rd_ready,
  input  logic              wr_valid,
  input  logic              wr_ready,
  output logic [CNT_W-1:0]  rd_beats,
  output logic [CNT_W-1:0]  wr_beats,
  output logic [BYTE_W-1:0] rd_bytes,
  output logic [BYTE_W-1:0] wr_bytes
);
  logic [NUM_CH-1:0]  ch_vld;
  logic [NUM_CH-1:0]  ch_rdy;
  logic [NUM_CH-1:0]  ch_beat;
  logic [CNT_W-1:0]   ch_res  [NUM_CH];
  logic [BYTE_W-1:0]  ch_byte [NUM_CH];

  always_comb begin
    ch_vld[CH_RD] = rd_valid;
    ch_rdy[CH_RD] = rd_ready;
    ch_vld[CH_WR] = wr_valid;
    ch_rdy[CH_WR] = wr_ready;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    beat_detect u_det (
      .vld  (ch_vld[c]),
      .rdy  (ch_rdy[c]),
      .win  (win_active),
      .beat (ch_beat[c])
    );

    beat_tally #(.CNT_W(CNT_W)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (ch_beat[c]),
      .capture (capture),
      .result  (ch_res[c])
    );

    byte_scale #(.IN_W(CNT_W), .SHIFT(SHIFT)) u_scale (
      .beats (ch_res[c]),
      .bytes (ch_byte[c])
    );
  end

  assign rd_beats = ch_res[CH_RD];
  assign wr_beats = ch_res[CH_WR];
  assign rd_bytes = ch_byte[CH_RD];
  assign wr_bytes = ch_byte[CH_WR];

  a_r4_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_active && !capture) |=> ($stable(rd_beats) && $stable(wr_beats)));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (rd_beats == '0 && wr_beats == '0));
endmodule

// File: tb/axi_beat_counter_test.sv
module axi_beat_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_active = 1'b0, capture = 1'b0;
  logic rd_valid = 1'b0, rd_ready = 1'b0, wr_valid = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_beats, wr_beats;
  logic [35:0] rd_bytes, wr_bytes;
  logic [3:0]  s_rd_beats, s_wr_beats;
  logic [7:0]  s_rd_bytes, s_wr_bytes;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_beat_counter uut (
    .clk(clk), .rst_n(rst_n), .win_active(win_active), .capture(capture),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_beats(rd_beats), .wr_beats(wr_beats), .rd_bytes(rd_bytes), .wr_bytes(wr_bytes)
  );

  // narrow copy used for the saturation check
  axi_beat_counter #(.CNT_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .win_active(win_active), .capture(capture),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_beats(s_rd_beats), .wr_beats(s_wr_beats), .rd_bytes(s_rd_bytes), .wr_bytes(s_wr_bytes)
  );

  // {win, cap, rv, rr, wv, wr, expected rd result, expected wr result}
  localparam logic [21:0] VEC [NV] = '{
    {6'b101100, 8'd0, 8'd0},   // R2 read handshake
    {6'b101011, 8'd0, 8'd0},   // R2 valid only, R3 write handshake
    {6'b100110, 8'd0, 8'd0},   // R2 R3 ready only / valid only
    {6'b101111, 8'd0, 8'd0},   // both channels
    {6'b001111, 8'd0, 8'd0},   // R4 window closed
    {6'b111100, 8'd3, 8'd2},   // R5 beat on capture
    {6'b100011, 8'd3, 8'd2},   // R6 hold, R9 write only
    {6'b101111, 8'd3, 8'd2},
    {6'b110000, 8'd1, 8'd2},   // R5 restart proven
    {6'b110000, 8'd0, 8'd0},   // back-to-back capture
    {6'b101100, 8'd0, 8'd0},
    {6'b011111, 8'd1, 8'd0}    // R4 closed window on capture cycle
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c);
    {win_active, capture, rd_valid, rd_ready, wr_valid, wr_ready} = c;
  endtask

  task automatic step(input logic [5:0] c);
    @(negedge clk);
    drive(c);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_beats", rd_beats, 0);
    chk("R1 wr_beats", wr_beats, 0);
    chk("R1 rd_bytes", rd_bytes, 0);
    chk("R1 wr_bytes", wr_bytes, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21:16]);
      chk("R2 R5 rd result", rd_beats, VEC[i][15:8]);
      chk("R3 R5 wr result", wr_beats, VEC[i][7:0]);
      chk("R8 rd bytes", rd_bytes, 64'(VEC[i][15:8]) * 16);
      chk("R8 wr bytes", wr_bytes, 64'(VEC[i][7:0]) * 16);
    end

    // R7: 20 read beats; the 4-bit copy must stop at 15
    for (int i = 0; i < 20; i++) step(6'b101100);
    step(6'b010000);
    chk("R7 wide rd", rd_beats, 20);
    chk("R7 narrow rd saturates", s_rd_beats, 15);
    chk("R7 R8 narrow rd bytes", s_rd_bytes, 240);
    chk("R9 wr untouched", wr_beats, 0);

    // R8 larger counts
    for (int i = 0; i < 300; i++) step((i < 5) ? 6'b101111 : 6'b101100);
    step(6'b010000);
    chk("R8 rd beats", rd_beats, 300);
    chk("R8 rd bytes", rd_bytes, 4800);
    chk("R9 wr beats", wr_beats, 5);
    chk("R8 wr bytes", wr_bytes, 80);

    // R6 results hold across idle cycles with window open
    for (int i = 0; i < 4; i++) step(6'b101010);
    chk("R6 rd held", rd_beats, 300);
    chk("R6 wr held", wr_beats, 5);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    drive(6'b000000);
    @(posedge clk);
    #1;
    chk("R1 rd after reset", rd_beats, 0);
    chk("R1 wr after reset", wr_bytes, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule